// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It walks a two-level translation structure that sits in ordinary memory. A requester presents the linear address. The walker reads one entry from the directory that the root base points to. If that entry is marked present, it reads one entry from the second-level table that the directory entry names. It then reports either the physical address or a page fault.

Memory is reached through a plain read port with a valid/ready request side and a separate data-valid return. Only one read is ever outstanding. The memory may take any number of cycles to answer. The walker handles one translation at a time. Its result comes back as a single-cycle response pulse, and no new request is taken until that pulse has been given.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and both `resp_valid` and `mem_rd_valid` are 0.
- R2: The cycle after a request is accepted (`req_valid` and `req_ready` both high at a clock edge), the walker raises `mem_rd_valid` with address `{root_base[31:12], 12'h000} + 4 * laddr[31:22]`. The root base is the value sampled at acceptance, and its low 12 bits are ignored. Address and valid hold steady until `mem_rd_ready` is seen.
- R3: An entry carries its 20-bit frame number in bits 31:12 and its present flag in bit 0, where 1 means present. Bits 11:1 have no effect on any result.
- R4: The cycle after a present directory entry is returned, the walker requests address `{dir_frame, 12'h000} + 4 * laddr[21:12]`.
- R5: The cycle after a present table entry is returned, `resp_valid` is 1 with `resp_fault` 0 and `resp_paddr = {tbl_frame, laddr[11:0]}`.
- R6: The cycle after a non-present directory entry is returned, `resp_valid` is 1 with `resp_fault` 1 and `resp_paddr` 0, and no second read is issued.
- R7: A non-present table entry gives `resp_valid` with `resp_fault` 1 and `resp_paddr` 0, one cycle after that entry is returned.
- R8: `resp_valid` lasts exactly one cycle. `req_ready` is 0 from the cycle after acceptance through the response cycle, and it is 1 again in the cycle after the response. A `req_valid` raised while busy is ignored.
- R9: The memory may answer after any delay. A `mem_rdata_valid` pulse that arrives while no read is outstanding has no effect.
- R10: No new read request is raised while a read is outstanding, and `mem_rd_valid` is never high in the same cycle as `resp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_laddr | input | 32 | Linear address to translate |
| root_base | input | 32 | Directory base address, 4 KiB aligned, sampled at acceptance |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_paddr | output | 32 | Physical address; 0 on a fault |
| resp_fault | output | 1 | Page fault, meaning a non-present entry was met |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory takes the read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rdata_valid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Entry value returned |

## Verification
Each result has a fixed place in time. The directory read is due one cycle after the accepting edge. The table read, or the directory-fault response, is due one cycle after the edge on which the directory entry is returned. The final response is due one cycle after the edge on which the table entry is returned, and `req_ready` comes back one cycle later. The bench drives each memory handshake itself, with chosen ready delays and latencies. It samples on the falling edge in every cycle in between. In each such cycle it compares every output with what its page-table model and this timing predict, so an early, late or missing event is caught in the exact cycle it goes wrong.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

   typedef enum logic [2:0] {
      WS_IDLE,
      WS_DIR_REQ,
      WS_DIR_WAIT,
      WS_TBL_REQ,
      WS_TBL_WAIT,
      WS_DONE
   } walk_state_e;

endpackage

// File: rtl/pt_entry_dec.sv
module pt_entry_dec #(
   parameter int ENTRY_W     = 32,
   parameter int FRAME_W     = 20,
   parameter int PRESENT_BIT = 0
) (
   input  logic [ENTRY_W-1:0] entry,
   output logic [FRAME_W-1:0] frame,
   output logic               present
);

   localparam int FLAG_W = ENTRY_W - FRAME_W;

   if (FLAG_W < 1) begin : g_bad_width
      $error("pt_entry_dec: entry too narrow for a flag field");
   end
   if (PRESENT_BIT >= FLAG_W) begin : g_bad_present
      $error("pt_entry_dec: present flag must lie below the frame field");
   end

   logic [FLAG_W-1:0] unused_flags;

   assign frame        = entry[ENTRY_W-1 -: FRAME_W];
   assign present      = entry[PRESENT_BIT];
   assign unused_flags = entry[FLAG_W-1:0];

endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
   parameter int ADDR_W      = 32,
   parameter int DIR_BITS    = 10,
   parameter int TBL_BITS    = 10,
   parameter int OFS_BITS    = 12,
   parameter int ENTRY_BYTES = 4,
   localparam int FRAME_W    = ADDR_W - OFS_BITS
) (
   input  logic [ADDR_W-1:0]  laddr,
   input  logic [FRAME_W-1:0] root_frame,
   input  logic [FRAME_W-1:0] tbl_frame,
   input  logic [FRAME_W-1:0] leaf_frame,
   output logic [ADDR_W-1:0]  dir_addr,
   output logic [ADDR_W-1:0]  tbl_addr,
   output logic [ADDR_W-1:0]  phys_addr
);

   localparam bit POW2_STRIDE = (ENTRY_BYTES & (ENTRY_BYTES - 1)) == 0;
   localparam int STRIDE_SH   = $clog2(ENTRY_BYTES);

   logic [DIR_BITS-1:0] dir_idx;
   logic [TBL_BITS-1:0] tbl_idx;
   logic [OFS_BITS-1:0] page_ofs;
   logic [ADDR_W-1:0]   dir_off;
   logic [ADDR_W-1:0]   tbl_off;

   assign dir_idx  = laddr[ADDR_W-1 -: DIR_BITS];
   assign tbl_idx  = laddr[OFS_BITS +: TBL_BITS];
   assign page_ofs = laddr[OFS_BITS-1:0];

   if (POW2_STRIDE) begin : g_shift_stride
      assign dir_off = ADDR_W'(dir_idx) << STRIDE_SH;
      assign tbl_off = ADDR_W'(tbl_idx) << STRIDE_SH;
   end else begin : g_mult_stride
      assign dir_off = ADDR_W'(dir_idx) * ADDR_W'(ENTRY_BYTES);
      assign tbl_off = ADDR_W'(tbl_idx) * ADDR_W'(ENTRY_BYTES);
   end

   assign dir_addr  = {root_frame, {OFS_BITS{1'b0}}} + dir_off;
   assign tbl_addr  = {tbl_frame,  {OFS_BITS{1'b0}}} + tbl_off;
   assign phys_addr = {leaf_frame, page_ofs};

endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
   import pt_walker_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic mem_rd_ready,
   input  logic mem_rdata_valid,
   input  logic entry_present,
   output logic req_ready,
   output logic mem_rd_valid,
   output logic rd_is_tbl,
   output logic resp_valid,
   output logic ld_req,
   output logic ld_tbl,
   output logic ld_res
);

   walk_state_e state_q, state_d;

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= WS_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         WS_IDLE:     if (req_valid)       state_d = WS_DIR_REQ;
         WS_DIR_REQ:  if (mem_rd_ready)    state_d = WS_DIR_WAIT;
         WS_DIR_WAIT: if (mem_rdata_valid) state_d = entry_present ? WS_TBL_REQ : WS_DONE;
         WS_TBL_REQ:  if (mem_rd_ready)    state_d = WS_TBL_WAIT;
         WS_TBL_WAIT: if (mem_rdata_valid) state_d = WS_DONE;
         WS_DONE:                          state_d = WS_IDLE;
         default:                          state_d = WS_IDLE;
      endcase
   end

   assign req_ready    = state_q == WS_IDLE;
   assign mem_rd_valid = (state_q == WS_DIR_REQ) || (state_q == WS_TBL_REQ);
   assign rd_is_tbl    = state_q == WS_TBL_REQ;
   assign resp_valid   = state_q == WS_DONE;
   assign ld_req       = req_ready && req_valid;
   assign ld_tbl       = (state_q == WS_DIR_WAIT) && mem_rdata_valid && entry_present;
   assign ld_res       = mem_rdata_valid &&
                         (((state_q == WS_DIR_WAIT) && !entry_present) ||
                          (state_q == WS_TBL_WAIT));

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
   parameter int ADDR_W      = 32,
   parameter int DIR_BITS    = 10,
   parameter int TBL_BITS    = 10,
   parameter int OFS_BITS    = 12,
   parameter int ENTRY_BYTES = 4,
   parameter int PRESENT_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_laddr,
   input  logic [ADDR_W-1:0] root_base,
   output logic              resp_valid,
   output logic [ADDR_W-1:0] resp_paddr,
   output logic              resp_fault,
   output logic              mem_rd_valid,
   input  logic              mem_rd_ready,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rdata_valid,
   input  logic [ADDR_W-1:0] mem_rdata
);

   localparam int FRAME_W = ADDR_W - OFS_BITS;

   if (DIR_BITS + TBL_BITS + OFS_BITS != ADDR_W) begin : g_bad_split
      $error("pt_walker: index and offset fields must cover the address");
   end
   if (ENTRY_BYTES < 1) begin : g_bad_stride
      $error("pt_walker: entry size must be positive");
   end

   logic               ld_req, ld_tbl, ld_res, rd_is_tbl;
   logic               entry_present;
   logic [FRAME_W-1:0] entry_frame;
   logic [ADDR_W-1:0]  laddr_q;
   logic [FRAME_W-1:0] root_frame_q;
   logic [FRAME_W-1:0] tbl_frame_q;
   logic [ADDR_W-1:0]  paddr_q;
   logic               fault_q;
   logic [ADDR_W-1:0]  dir_addr, tbl_addr, phys_addr;
   logic [OFS_BITS-1:0] unused_root_low;

   assign unused_root_low = root_base[OFS_BITS-1:0];

   pt_walk_fsm u_fsm (
      .clk             (clk),
      .rst_n           (rst_n),
      .req_valid       (req_valid),
      .mem_rd_ready    (mem_rd_ready),
      .mem_rdata_valid (mem_rdata_valid),
      .entry_present   (entry_present),
      .req_ready       (req_ready),
      .mem_rd_valid    (mem_rd_valid),
      .rd_is_tbl       (rd_is_tbl),
      .resp_valid      (resp_valid),
      .ld_req          (ld_req),
      .ld_tbl          (ld_tbl),
      .ld_res          (ld_res)
   );

   pt_entry_dec #(
      .ENTRY_W     (ADDR_W),
      .FRAME_W     (FRAME_W),
      .PRESENT_BIT (PRESENT_BIT)
   ) u_dec (
      .entry   (mem_rdata),
      .frame   (entry_frame),
      .present (entry_present)
   );

   pt_addr_gen #(
      .ADDR_W      (ADDR_W),
      .DIR_BITS    (DIR_BITS),
      .TBL_BITS    (TBL_BITS),
      .OFS_BITS    (OFS_BITS),
      .ENTRY_BYTES (ENTRY_BYTES)
   ) u_agen (
      .laddr      (laddr_q),
      .root_frame (root_frame_q),
      .tbl_frame  (tbl_frame_q),
      .leaf_frame (entry_frame),
      .dir_addr   (dir_addr),
      .tbl_addr   (tbl_addr),
      .phys_addr  (phys_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         laddr_q      <= '0;
         root_frame_q <= '0;
         tbl_frame_q  <= '0;
         paddr_q      <= '0;
         fault_q      <= 1'b0;
      end else begin
         if (ld_req) begin
            laddr_q      <= req_laddr;
            root_frame_q <= root_base[ADDR_W-1:OFS_BITS];
         end
         if (ld_tbl) tbl_frame_q <= entry_frame;
         if (ld_res) begin
            fault_q <= !entry_present;
            paddr_q <= entry_present ? phys_addr : '0;
         end
      end
   end

   assign mem_rd_addr = rd_is_tbl ? tbl_addr : dir_addr;
   assign resp_paddr  = paddr_q;
   assign resp_fault  = fault_q;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
   parameter int ADDR_W   = 32,
   parameter int OFS_BITS = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_laddr,
   input logic              resp_valid,
   input logic [ADDR_W-1:0] resp_paddr,
   input logic              resp_fault,
   input logic              mem_rd_valid,
   input logic              mem_rd_ready,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              mem_rdata_valid
);

   logic                rd_pending;
   logic [OFS_BITS-1:0] ofs_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_pending <= 1'b0;
         ofs_q      <= '0;
      end else begin
         if (mem_rd_valid && mem_rd_ready) rd_pending <= 1'b1;
         else if (mem_rdata_valid)         rd_pending <= 1'b0;
         if (req_valid && req_ready) ofs_q <= req_laddr[OFS_BITS-1:0];
      end
   end

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!mem_rd_valid && !resp_valid));

   // R2
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

   // R5
   ofs_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_fault) |-> (resp_paddr[OFS_BITS-1:0] == ofs_q));

   // R6
   fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_fault) |-> (resp_paddr == '0));

   // R8
   resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);

   // R8
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R10
   one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pending |-> !mem_rd_valid);

   // R10
   no_rd_with_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> !mem_rd_valid);

endmodule

bind pt_walker pt_walker_chk #(
   .ADDR_W   (ADDR_W),
   .OFS_BITS (OFS_BITS)
) u_chk (.*);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_laddr = '0;
   logic [31:0] root_base = '0;
   logic        resp_valid;
   logic [31:0] resp_paddr;
   logic        resp_fault;
   logic        mem_rd_valid;
   logic        mem_rd_ready = 1'b0;
   logic [31:0] mem_rd_addr;
   logic        mem_rdata_valid = 1'b0;
   logic [31:0] mem_rdata = '0;

   int tests = 0;
   int fails = 0;

   logic [31:0] pmem [logic [31:0]];

   always #10 clk = ~clk;

   pt_walker u0 (.*);

   function automatic logic [31:0] peek(input logic [31:0] a);
      return pmem.exists(a) ? pmem[a] : 32'h0;
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   // Serve one memory read: ready after rdy_dly cycles, data lat cycles later.
   task automatic serve(input logic [31:0] exp_a, input int rdy_dly, input int lat,
                        input bit noise, input string rq);
      for (int i = 0; i <= rdy_dly; i++) begin
         chk(mem_rd_valid == 1'b1, {rq, " read valid"}, 32'(mem_rd_valid), 32'd1);
         chk(mem_rd_addr == exp_a, {rq, " read addr"}, mem_rd_addr, exp_a);
         chk(resp_valid == 1'b0 && req_ready == 1'b0, "R8 busy during read", 32'(resp_valid), 32'd0);
         if (i == rdy_dly) mem_rd_ready = 1'b1;
         @(negedge clk);
         mem_rd_ready = 1'b0;
      end
      for (int i = 0; i < lat; i++) begin
         chk(mem_rd_valid == 1'b0, "R10 no read while outstanding", 32'(mem_rd_valid), 32'd0);
         chk(resp_valid == 1'b0, "R9 no result before data", 32'(resp_valid), 32'd0);
         chk(req_ready == 1'b0, "R8 not ready while waiting", 32'(req_ready), 32'd0);
         if (noise) begin
            req_valid = 1'b1;
            req_laddr = 32'hFFFF_FFFF;
         end
         @(negedge clk);
      end
      req_valid = 1'b0;
      mem_rdata_valid = 1'b1;
      mem_rdata = peek(exp_a);
      @(negedge clk);
      mem_rdata_valid = 1'b0;
      mem_rdata = 32'hA5A5_A5A5;
   endtask

   task automatic walk(input logic [31:0] la, input logic [31:0] root, input int rdy_dly,
                       input int lat, input bit flip_root, input bit noise);
      logic [31:0] dir_a, de, tbl_a, te, exp_pa;
      dir_a = {root[31:12], 12'h000} + {20'h0, la[31:22], 2'b00};
      de    = peek(dir_a);
      tbl_a = {de[31:12], 12'h000} + {20'h0, la[21:12], 2'b00};
      te    = peek(tbl_a);
      exp_pa = te[0] ? {te[31:12], la[11:0]} : 32'h0;

      chk(req_ready == 1'b1, "R8 ready before request", 32'(req_ready), 32'd1);
      req_valid = 1'b1;
      req_laddr = la;
      root_base = root;
      @(negedge clk);
      req_valid = 1'b0;
      req_laddr = 32'hDEAD_BEEF;
      if (flip_root) root_base = ~root;
      chk(req_ready == 1'b0, "R8 busy after accept", 32'(req_ready), 32'd0);
      serve(dir_a, rdy_dly, lat, noise, "R2");
      if (!de[0]) begin
         chk(resp_valid == 1'b1, "R6 response after absent directory entry", 32'(resp_valid), 32'd1);
         chk(resp_fault == 1'b1, "R6 fault flag", 32'(resp_fault), 32'd1);
         chk(resp_paddr == 32'h0, "R6 address zero on fault", resp_paddr, 32'h0);
         chk(mem_rd_valid == 1'b0, "R6 no second read", 32'(mem_rd_valid), 32'd0);
      end else begin
         serve(tbl_a, rdy_dly, lat, noise, "R4");
         chk(resp_valid == 1'b1, "R5 response after table entry", 32'(resp_valid), 32'd1);
         if (te[0]) begin
            chk(resp_fault == 1'b0, "R5 no fault", 32'(resp_fault), 32'd0);
            chk(resp_paddr == exp_pa, "R5 physical address", resp_paddr, exp_pa);
         end else begin
            chk(resp_fault == 1'b1, "R7 fault on absent table entry", 32'(resp_fault), 32'd1);
            chk(resp_paddr == 32'h0, "R7 address zero on fault", resp_paddr, 32'h0);
         end
         chk(mem_rd_valid == 1'b0, "R10 no read with response", 32'(mem_rd_valid), 32'd0);
      end
      chk(req_ready == 1'b0, "R8 not ready in response cycle", 32'(req_ready), 32'd0);
      @(negedge clk);
      chk(resp_valid == 1'b0, "R8 single-cycle response", 32'(resp_valid), 32'd0);
      chk(req_ready == 1'b1, "R8 ready after response", 32'(req_ready), 32'd1);
      chk(mem_rd_valid == 1'b0, "R1 idle has no read", 32'(mem_rd_valid), 32'd0);
   endtask

   initial begin
      // directory at 0x5000
      pmem[32'h0000_5000] = 32'h0001_0001;
      pmem[32'h0000_5004] = 32'h0002_0000;          // absent, frame bits set
      pmem[32'h0000_5008] = 32'h0008_0FFF;          // present, R3 flag bits set
      // table at 0x10000
      pmem[32'h0001_0000] = 32'h0000_1001;
      pmem[32'h0001_0004] = 32'h1234_5000;          // absent
      pmem[32'h0001_0008] = 32'h0000_D001;
      pmem[32'h0001_0FFC] = 32'h0000_5FFF;          // present, R3 flag bits set
      // table at 0x80000
      pmem[32'h0008_0000] = 32'h0000_A001;
      pmem[32'h0008_0004] = 32'h0000_C001;
      pmem[32'h0008_0008] = 32'hFFFF_FFFE;          // absent, all other bits set
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R8 watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 32'd1);
      chk(resp_valid == 1'b0, "R1 no response in reset", 32'(resp_valid), 32'd0);
      chk(mem_rd_valid == 1'b0, "R1 no read in reset", 32'(mem_rd_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && resp_valid == 1'b0 && mem_rd_valid == 1'b0,
          "R1 idle after reset", {29'h0, req_ready, resp_valid, mem_rd_valid}, 32'h4);

      // R9: stray data while idle has no effect
      mem_rdata_valid = 1'b1;
      mem_rdata = 32'h0000_C001;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(resp_valid == 1'b0 && mem_rd_valid == 1'b0 && req_ready == 1'b1,
             "R9 stray data ignored", {29'h0, req_ready, resp_valid, mem_rd_valid}, 32'h4);
      end
      mem_rdata_valid = 1'b0;

      walk(32'h0000_0001, 32'h0000_5000, 0, 0, 1'b0, 1'b0);
      walk(32'h0000_1001, 32'h0000_5000, 1, 2, 1'b0, 1'b0);
      walk(32'h003F_F001, 32'h0000_5000, 0, 3, 1'b0, 1'b0);   // R3
      walk(32'h0040_0000, 32'h0000_5000, 2, 1, 1'b0, 1'b0);
      walk(32'h0080_1004, 32'h0000_5000, 0, 5, 1'b1, 1'b1);   // R2 sampled root, R8 ignored req
      walk(32'h0080_2004, 32'h0000_5000, 3, 0, 1'b0, 1'b0);
      walk(32'h00B0_0001, 32'h0000_5000, 1, 1, 1'b0, 1'b0);
      walk(32'h0080_0FFF, 32'h0000_5ABC, 0, 7, 1'b0, 1'b0);   // R2 low root bits ignored
      walk(32'h0080_1000, 32'h0000_5000, 4, 12, 1'b1, 1'b1);  // R9 long latency
      walk(32'h0C00_0123, 32'h0000_5000, 0, 0, 1'b0, 1'b0);   // absent entry beyond the filled ones

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule